// File: doc/BRIEF.md
# Latency-Aligned Bit Error Meter

This block measures how many bits a demodulator gets wrong. The transmit side gives it the reference stream as a bit plus a valid strobe. The receive side gives it the recovered stream the same way. A demodulator takes a number of bit periods to produce each decision. The block therefore passes every reference bit through a shift register and takes it from a tap chosen at run time, so that each recovered bit is compared with the reference bit it stands for.

A start pulse clears the block and latches the alignment depth. From then on, every accepted receive strobe compares one bit. The bit counter and the error counter advance as comparisons are made. When the bit counter reaches the run length set by a parameter, the block raises a one-cycle done pulse and freezes both counts. The counts stay frozen until the next start pulse, which begins the measurement of the next operating point. The default run length is ten thousand bits. Shorter runs can be set for simulation.

Top module: `bit_err_meter`

## Requirements
- R1: After reset, busy_o and done_o are low, and bit_cnt_o and err_cnt_o are zero.
- R2: A start_i pulse has an effect at the next clock edge. That edge clears both counts and the delay line, latches dly_i and raises busy_o. Strobes in the start cycle are dropped, and start_i also wins over an ongoing run.
- R3: A comparison made with latched depth d uses one of two reference bits. For d = 0 it is the tx_bit_i presented in the same cycle. For d > 0 it is the bit pushed by the d-th most recent earlier tx_vld_i strobe of the run.
- R4: With depth d, rx_vld_i strobes are ignored until d tx_vld_i strobes have been accepted in the current run.
- R5: Each accepted comparison raises bit_cnt_o by one at the next edge. It also raises err_cnt_o by one when rx_bit_i differs from the reference bit.
- R6: err_cnt_o saturates at 2^ERR_W-1 and never wraps.
- R7: On the comparison that brings bit_cnt_o to RUN_LEN, done_o is high for exactly the following cycle and busy_o falls at the same edge. A mismatch on that final bit is still counted.
- R8: While busy_o is low, strobes have no effect, and bit_cnt_o and err_cnt_o hold their values until the next start.
- R9: A dly_i value above MAX_DLY is latched as MAX_DLY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear and begin a measurement run |
| dly_i | input | DLY_W | Alignment depth in bit periods, latched at start |
| tx_vld_i | input | 1 | Reference bit valid |
| tx_bit_i | input | 1 | Reference bit |
| rx_vld_i | input | 1 | Recovered bit valid, requests a comparison |
| rx_bit_i | input | 1 | Recovered bit |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at end of run |
| bit_cnt_o | output | CNT_W | Bits compared in this run |
| err_cnt_o | output | ERR_W | Mismatches in this run, saturating |

## Verification
The final comparison of a run and an error increment can fall on the same edge. The bench provokes this by injecting a single mismatch on exactly the last compared bit. It expects done_o together with an error count of one. A second coincidence is a start pulse arriving together with both strobes. It is driven both at the head of every run and in the middle of a run. The bench expects both counts to be zero after that edge, which shows the strobes were dropped. All delays from zero to one past the maximum are swept against four error patterns. The expected counts are computed arithmetically from the depth, the run length and the saturation limit.

// File: rtl/bem_pkg.sv
package bem_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;
endpackage

// File: rtl/bem_dly_line.sv
module bem_dly_line #(
  parameter int MAX_DLY = 32,
  parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             bit_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic             ref_o,
  output logic             rdy_o
);
  localparam logic [DLY_W-1:0] FillMax = DLY_W'(MAX_DLY);

  logic [MAX_DLY-1:0] tap_w;
  logic [DLY_W-1:0]   fill_q;

  for (genvar i = 0; i < MAX_DLY; i++) begin : g_stg
    logic d_w;
    logic q;
    if (i == 0) begin : g_head
      assign d_w = bit_i;
    end else begin : g_body
      assign d_w = tap_w[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= 1'b0;
      else if (clr_i)  q <= 1'b0;
      else if (push_i) q <= d_w;
    end
    assign tap_w[i] = q;
  end

  // pushes seen since clear, held at the line depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          fill_q <= '0;
    else if (clr_i)                       fill_q <= '0;
    else if (push_i && fill_q != FillMax) fill_q <= fill_q + 1'b1;
  end

  // depth 0 compares against the bit offered in the same cycle
  always_comb begin
    ref_o = bit_i;
    for (int i = 1; i <= MAX_DLY; i++) begin
      if (sel_i == DLY_W'(i)) ref_o = tap_w[i-1];
    end
  end

  assign rdy_o = (fill_q >= sel_i);

  // R4
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FillMax);

  // R4
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !push_i) |=> $stable(fill_q));
endmodule

// File: rtl/bem_err_cnt.sv
module bem_err_cnt #(
  parameter int ERR_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cmp_i,
  input  logic             ref_i,
  input  logic             rx_i,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [ERR_W-1:0] ErrMax = {ERR_W{1'b1}};

  logic [ERR_W-1:0] err_q;
  logic             miss_w;

  assign miss_w = cmp_i && (ref_i != rx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       err_q <= '0;
    else if (clr_i)                    err_q <= '0;
    else if (miss_w && err_q != ErrMax) err_q <= err_q + 1'b1;
  end

  assign err_o = err_q;

  // R6
  err_sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && err_q == ErrMax) |=> err_q == ErrMax);

  // R5
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_q == $past(err_q) || err_q == $past(err_q) + 1'b1));

  // R5
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !cmp_i) |=> $stable(err_q));
endmodule

// File: rtl/bem_run_ctl.sv
module bem_run_ctl
  import bem_pkg::*;
#(
  parameter int RUN_LEN = 10000,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rx_vld_i,
  input  logic             rdy_i,
  output logic             acc_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] FullCnt = CNT_W'(RUN_LEN);

  run_st_e          st_q;
  logic [CNT_W-1:0] bit_q;
  logic             done_q;
  logic             last_w;

  assign acc_o  = (st_q == ST_RUN) && rx_vld_i && rdy_i && !start_i;
  assign last_w = acc_o && (bit_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_RUN;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_w;
      if (acc_o) bit_q <= bit_q + 1'b1;
      if (last_w) st_q <= ST_IDLE;
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign done_o    = done_q;
  assign bit_cnt_o = bit_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R7
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (bit_q == FullCnt && st_q == ST_IDLE));

  // R7
  bit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= FullCnt);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> $stable(bit_q));

  // R2
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (bit_q == '0 && st_q == ST_RUN && !done_q));
endmodule

// File: rtl/bit_err_meter.sv
module bit_err_meter #(
  parameter int RUN_LEN = 10000,
  parameter int MAX_DLY = 32,
  parameter int ERR_W   = 14,
  parameter int DLY_W   = $clog2(MAX_DLY + 1),
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tx_vld_i,
  input  logic             tx_bit_i,
  input  logic             rx_vld_i,
  input  logic             rx_bit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam logic [DLY_W-1:0] DlyMax = DLY_W'(MAX_DLY);

  logic [DLY_W-1:0] dly_q;
  logic             push_w;
  logic             ref_w;
  logic             rdy_w;
  logic             acc_w;

  // depth is clamped once, at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dly_q <= '0;
    else if (start_i) dly_q <= (dly_i > DlyMax) ? DlyMax : dly_i;
  end

  assign push_w = busy_o && tx_vld_i && !start_i;

  bem_dly_line #(
    .MAX_DLY (MAX_DLY),
    .DLY_W   (DLY_W)
  ) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .push_i (push_w),
    .bit_i  (tx_bit_i),
    .sel_i  (dly_q),
    .ref_o  (ref_w),
    .rdy_o  (rdy_w)
  );

  bem_run_ctl #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .rx_vld_i  (rx_vld_i),
    .rdy_i     (rdy_w),
    .acc_o     (acc_w),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .bit_cnt_o (bit_cnt_o)
  );

  bem_err_cnt #(
    .ERR_W (ERR_W)
  ) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .cmp_i  (acc_w),
    .ref_i  (ref_w),
    .rx_i   (rx_bit_i),
    .err_o  (err_cnt_o)
  );

  // R9
  dly_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_q <= DlyMax);

  // R4
  fill_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rx_vld_i && !rdy_w && !start_i) |=> $stable(bit_cnt_o));

  // R5
  err_le_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(err_cnt_o) <= 32'(bit_cnt_o));

  // R8
  idle_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(err_cnt_o));
endmodule

// File: tb/tb_bit_err_meter.sv
module tb_bit_err_meter;
  localparam int RL = 40;
  localparam int MD = 8;
  localparam int EW = 4;
  localparam int DW = $clog2(MD + 1);
  localparam int CW = $clog2(RL + 1);
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] dly = '0;
  logic tx_vld = 1'b0, tx_bit = 1'b0, rx_vld = 1'b0, rx_bit = 1'b0;
  logic busy, done;
  logic [CW-1:0] bit_cnt;
  logic [EW-1:0] err_cnt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bit_err_meter #(.RUN_LEN(RL), .MAX_DLY(MD), .ERR_W(EW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dly_i(dly),
    .tx_vld_i(tx_vld), .tx_bit_i(tx_bit), .rx_vld_i(rx_vld), .rx_bit_i(rx_bit),
    .busy_o(busy), .done_o(done), .bit_cnt_o(bit_cnt), .err_cnt_o(err_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // inputs applied after a falling edge, outputs read at the next falling edge
  task automatic cyc(input logic st, input int d, input logic tv, input logic tb,
                     input logic rv, input logic rb);
    start = st; dly = DW'(d); tx_vld = tv; tx_bit = tb; rx_vld = rv; rx_bit = rb;
    @(negedge clk);
    start = 1'b0; tx_vld = 1'b0; rx_vld = 1'b0;
  endtask

  function automatic logic gen(input int k);
    return logic'(((k * 13 + (k >> 3)) % 3) == 0);
  endfunction

  function automatic logic errf(input int k, input int de, input int mode);
    case (mode)
      1: return logic'((k % 7) == 3);
      2: return 1'b1;
      3: return logic'(k == de + RL - 1);
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_case(input int d, input int mode);
    int de, exp_err, exp_bit;
    logic e, rb;
    de = (d > MD) ? MD : d;
    // R2: strobes in the start cycle are dropped
    cyc(1'b1, d, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R2 start bit_cnt", int'(bit_cnt), 0);
    check("R2 start err_cnt", int'(err_cnt), 0);
    check("R2 start busy", int'(busy), 1);
    exp_err = 0;
    for (int k = 0; k < de + RL; k++) begin
      if (k >= de) begin
        e  = errf(k, de, mode);
        rb = gen(k - de) ^ e;
        if (e) exp_err++;
      end else begin
        rb = ~gen(k);
      end
      cyc(1'b0, 0, 1'b1, gen(k), 1'b1, rb);
      exp_bit = (k >= de) ? k - de + 1 : 0;
      if (d > MD) check("R9 clamped depth bit_cnt", int'(bit_cnt), exp_bit);
      else if (k < de) check("R4 suppressed bit_cnt", int'(bit_cnt), exp_bit);
      else check("R3 R5 bit_cnt", int'(bit_cnt), exp_bit);
      if (k < de + RL - 1) begin
        check("R7 no early done", int'(done), 0);
        if (mode == 1 && (k % 5) == 4) begin
          cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
          check("R5 idle cycle bit_cnt", int'(bit_cnt), exp_bit);
        end
      end
    end
    check("R7 done pulse", int'(done), 1);
    check("R7 busy falls", int'(busy), 0);
    if (mode == 2) check("R6 saturated err_cnt", int'(err_cnt), EMAX);
    else if (mode == 3) check("R7 last bit error", int'(err_cnt), 1);
    else check("R3 R5 err_cnt", int'(err_cnt), (exp_err > EMAX) ? EMAX : exp_err);
    exp_err = int'(err_cnt);
    // R8: strobes after done have no effect
    cyc(1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R7 done one cycle", int'(done), 0);
    cyc(1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R8 bit_cnt held", int'(bit_cnt), RL);
    check("R8 err_cnt held", int'(err_cnt), exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 bit_cnt", int'(bit_cnt), 0);
    check("R1 err_cnt", int'(err_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: strobes before any start are ignored
    cyc(1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R8 pre-start bit_cnt", int'(bit_cnt), 0);
    check("R8 pre-start err_cnt", int'(err_cnt), 0);
    // R2: restart in mid-run
    cyc(1'b1, 2, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R2 mid-run bit_cnt", int'(bit_cnt), 8);
    check("R2 mid-run err_cnt", int'(err_cnt), 8);
    cyc(1'b1, 0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R2 restart bit_cnt", int'(bit_cnt), 0);
    check("R2 restart err_cnt", int'(err_cnt), 0);
    check("R2 restart busy", int'(busy), 1);
    for (int d = 0; d <= MD + 1; d++)
      for (int m = 0; m < 4; m++) run_case(d, m);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule